// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the 16-bit operand address for one instruction of a small 8-bit processor core. The decoder hands it an addressing mode, the operand bytes that followed the opcode, the two index register values, the address of the byte after the whole instruction, and the already evaluated branch condition. One clock later it returns the effective address, whether a data memory access is needed, and the program counter the core should continue from.

Absolute (extended) addresses come straight from the two operand bytes. Indexed addresses add an unsigned 8-bit displacement to X or Y. Register-only (inherent) instructions need no access. Relative branches add a signed 8-bit displacement to the next-instruction address when taken and fall through otherwise. All sums wrap modulo 65536. The unit always accepts requests. Each accepted request yields exactly one response, and the result registers keep their value until the next request.

Top module: `eagu_top`

## Requirements
- R1: While rst_ni is low, and after it is released with no request, rsp_valid_o, ea_o, mem_access_o and pc_o are all zero.
- R2: req_ready_o is always 1. A request with req_valid_i high at a rising edge makes rsp_valid_o high for exactly the following cycle, and the results appear in that same cycle.
- R3: Mode code 0 (absolute) gives ea_o = {op_hi_i, op_lo_i}, mem_access_o = 1 and pc_o = pc_next_i.
- R4: Mode code 1 (indexed on X) gives ea_o = (idx_x_i + op_lo_i) mod 65536, with op_lo_i zero-extended, mem_access_o = 1 and pc_o = pc_next_i.
- R5: Mode code 2 (indexed on Y) gives ea_o = (idx_y_i + op_lo_i) mod 65536, with op_lo_i zero-extended, mem_access_o = 1 and pc_o = pc_next_i.
- R6: Mode code 3 (inherent) gives mem_access_o = 0, ea_o = 0 and pc_o = pc_next_i.
- R7: Mode code 4 (relative) with cond_true_i = 1 gives pc_o = ea_o = (pc_next_i + sign-extended op_lo_i) mod 65536 and mem_access_o = 0.
- R8: Mode code 4 with cond_true_i = 0 gives pc_o = pc_next_i, while ea_o still holds the computed branch target and mem_access_o = 0.
- R9: In a cycle with req_valid_i low, rsp_valid_o falls to 0 and ea_o, mem_access_o and pc_o keep their values, whatever the other inputs do.
- R10: The unused mode codes 5, 6 and 7 behave as inherent: mem_access_o = 0, ea_o = 0 and pc_o = pc_next_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request qualifier |
| req_ready_o | output | 1 | Always high; the unit accepts a request every cycle |
| mode_i | input | 3 | Addressing mode code (0 absolute, 1 X-indexed, 2 Y-indexed, 3 inherent, 4 relative) |
| op_hi_i | input | 8 | First operand byte (high address byte in absolute mode) |
| op_lo_i | input | 8 | Second operand byte, or the displacement |
| idx_x_i | input | 16 | X index register value |
| idx_y_i | input | 16 | Y index register value |
| pc_next_i | input | 16 | Address of the byte after the complete instruction |
| cond_true_i | input | 1 | Branch condition result |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| ea_o | output | 16 | Effective address |
| mem_access_o | output | 1 | A data memory access is required |
| pc_o | output | 16 | Program counter to continue from |

## Verification
On every cycle the assertions check the response strobe against the request of the previous cycle, that the results hold when no request arrives, the absolute and X-indexed address formation, the missing access flag for inherent requests, and the fall-through of a branch that is not taken. Only the bench scenarios show the wrap-around of indexed and relative sums near the top and bottom of the address space, the full range of sign-extended displacements, Y indexing, and the handling of the unused mode codes. They do this by sweeping every displacement byte across all mode codes, both condition values and several base addresses close to the wrap points.

// File: rtl/eagu_pkg.sv
package eagu_pkg;
  parameter int unsigned ADDR_W = 16;
  parameter int unsigned OFF_W  = 8;
  parameter int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_EXT   = 3'd0,
    MODE_IDX_X = 3'd1,
    MODE_IDX_Y = 3'd2,
    MODE_INH   = 3'd3,
    MODE_REL   = 3'd4
  } mode_e;

  typedef struct packed {
    logic [ADDR_W-1:0] ea;
    logic              mem;
    logic [ADDR_W-1:0] pc;
  } result_t;
endpackage

// File: rtl/eagu_operand_sel.sv
module eagu_operand_sel
  import eagu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned OW = OFF_W
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [OW-1:0]     off_i,
  input  logic [AW-1:0]     idx_x_i,
  input  logic [AW-1:0]     idx_y_i,
  input  logic [AW-1:0]     pc_next_i,
  output logic [AW-1:0]     base_o,
  output logic [AW-1:0]     off_ext_o
);
  localparam int unsigned EXT_W = AW - OW;

  logic [AW-1:0] off_zext, off_sext;
  assign off_zext = {{EXT_W{1'b0}}, off_i};
  assign off_sext = {{EXT_W{off_i[OW-1]}}, off_i};

  always_comb begin
    case (mode_e'(mode_i))
      MODE_IDX_Y: base_o = idx_y_i;
      MODE_REL:   base_o = pc_next_i;
      default:    base_o = idx_x_i;
    endcase
    // branch displacements are signed, index displacements are not
    off_ext_o = (mode_e'(mode_i) == MODE_REL) ? off_sext : off_zext;
  end
endmodule

// File: rtl/eagu_adder.sv
module eagu_adder #(
  parameter int unsigned AW = eagu_pkg::ADDR_W
) (
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  output logic [AW-1:0] sum_o
);
  // carry out dropped: address space wraps
  assign sum_o = a_i + b_i;
endmodule

// File: rtl/eagu_result_stage.sv
module eagu_result_stage
  import eagu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  result_t res_i,
  output logic    valid_o,
  output result_t res_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= en_i;
      if (en_i) res_o <= res_i;
    end
  end
endmodule

// File: rtl/eagu_top.sv
module eagu_top
  import eagu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned OW = OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [OW-1:0]     op_hi_i,
  input  logic [OW-1:0]     op_lo_i,
  input  logic [AW-1:0]     idx_x_i,
  input  logic [AW-1:0]     idx_y_i,
  input  logic [AW-1:0]     pc_next_i,
  input  logic              cond_true_i,
  output logic              rsp_valid_o,
  output logic [AW-1:0]     ea_o,
  output logic              mem_access_o,
  output logic [AW-1:0]     pc_o
);
  localparam int unsigned ABS_W = 2 * OW;

  logic [AW-1:0] base, off_ext, sum, abs_addr;
  result_t       res_d, res_q;

  generate
    if (AW > ABS_W) begin : g_abs_wide
      assign abs_addr = {{(AW-ABS_W){1'b0}}, op_hi_i, op_lo_i};
    end else begin : g_abs_exact
      assign abs_addr = {op_hi_i, op_lo_i};
    end
  endgenerate

  eagu_operand_sel #(.AW(AW), .OW(OW)) u_sel (
    .mode_i    (mode_i),
    .off_i     (op_lo_i),
    .idx_x_i   (idx_x_i),
    .idx_y_i   (idx_y_i),
    .pc_next_i (pc_next_i),
    .base_o    (base),
    .off_ext_o (off_ext)
  );

  eagu_adder #(.AW(AW)) u_add (
    .a_i   (base),
    .b_i   (off_ext),
    .sum_o (sum)
  );

  always_comb begin
    res_d     = '0;
    res_d.pc  = pc_next_i;
    case (mode_e'(mode_i))
      MODE_EXT: begin
        res_d.ea  = abs_addr;
        res_d.mem = 1'b1;
      end
      MODE_IDX_X, MODE_IDX_Y: begin
        res_d.ea  = sum;
        res_d.mem = 1'b1;
      end
      MODE_REL: begin
        res_d.ea = sum;
        if (cond_true_i) res_d.pc = sum;
      end
      default: ; // inherent and unused codes: no access
    endcase
  end

  eagu_result_stage u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (req_valid_i),
    .res_i   (res_d),
    .valid_o (rsp_valid_o),
    .res_o   (res_q)
  );

  assign req_ready_o  = 1'b1;
  assign ea_o         = res_q.ea;
  assign mem_access_o = res_q.mem;
  assign pc_o         = res_q.pc;
endmodule

// File: rtl/eagu_checker.sv
module eagu_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [2:0]  mode_i,
  input logic [7:0]  op_hi_i,
  input logic [7:0]  op_lo_i,
  input logic [15:0] idx_x_i,
  input logic [15:0] pc_next_i,
  input logic        cond_true_i,
  input logic        rsp_valid_o,
  input logic [15:0] ea_o,
  input logic        mem_access_o,
  input logic [15:0] pc_o
);
  p_rsp_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_hold_when_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && $stable(ea_o) && $stable(pc_o) && $stable(mem_access_o)));

  p_abs_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 3'd0) |=> (ea_o == {$past(op_hi_i), $past(op_lo_i)} && mem_access_o));

  p_idx_x_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 3'd1) |=> (ea_o == 16'($past(idx_x_i) + {8'd0, $past(op_lo_i)}) && mem_access_o));

  p_inh_no_access_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 3'd3) |=> (!mem_access_o && pc_o == $past(pc_next_i)));

  p_branch_fallthrough_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 3'd4 && !cond_true_i) |=> (pc_o == $past(pc_next_i) && !mem_access_o));
endmodule

bind eagu_top eagu_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .mode_i       (mode_i),
  .op_hi_i      (op_hi_i),
  .op_lo_i      (op_lo_i),
  .idx_x_i      (idx_x_i),
  .pc_next_i    (pc_next_i),
  .cond_true_i  (cond_true_i),
  .rsp_valid_o  (rsp_valid_o),
  .ea_o         (ea_o),
  .mem_access_o (mem_access_o),
  .pc_o         (pc_o)
);

// File: tb/eagu_top_tb.sv
module eagu_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  mode = '0;
  logic [7:0]  op_hi = '0, op_lo = '0;
  logic [15:0] idx_x = '0, idx_y = '0, pc_next = '0;
  logic        cond = 1'b0;
  logic        rsp_valid, mem_access;
  logic [15:0] ea, pc;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eagu_top u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .mode_i       (mode),
    .op_hi_i      (op_hi),
    .op_lo_i      (op_lo),
    .idx_x_i      (idx_x),
    .idx_y_i      (idx_y),
    .pc_next_i    (pc_next),
    .cond_true_i  (cond),
    .rsp_valid_o  (rsp_valid),
    .ea_o         (ea),
    .mem_access_o (mem_access),
    .pc_o         (pc)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic one_request(input int m, input int lo, input int hi, input int x,
                             input int y, input int pcn, input bit c);
    int exp_ea, exp_pc, exp_mem, soff;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; mode = 3'(m); op_lo = 8'(lo); op_hi = 8'(hi);
    idx_x = 16'(x); idx_y = 16'(y); pc_next = 16'(pcn); cond = c;
    soff = (lo >= 128) ? lo - 256 : lo;
    exp_pc = pcn; exp_ea = 0; exp_mem = 0;
    case (m)
      0: begin tag = "R3"; exp_ea = hi * 256 + lo; exp_mem = 1; end
      1: begin tag = "R4"; exp_ea = (x + lo) % 65536; exp_mem = 1; end
      2: begin tag = "R5"; exp_ea = (y + lo) % 65536; exp_mem = 1; end
      3: tag = "R6";
      4: begin
        exp_ea = (pcn + soff + 65536) % 65536;
        if (c) begin tag = "R7"; exp_pc = exp_ea; end
        else tag = "R8";
      end
      default: tag = "R10";
    endcase
    chk("R2", "ready", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "rsp_valid", int'(rsp_valid), 1);
    chk(tag, "ea", int'(ea), exp_ea);
    chk(tag, "mem", int'(mem_access), exp_mem);
    chk(tag, "pc", int'(pc), exp_pc);
    // scramble idle inputs; result must not move
    mode = 3'(m + 3); op_lo = 8'(~lo); op_hi = 8'(~hi);
    idx_x = 16'(x ^ 16'h1234); idx_y = 16'(y ^ 16'h4321);
    pc_next = 16'(pcn + 77); cond = ~c;
    @(negedge clk);
    chk("R9", "rsp_valid idle", int'(rsp_valid), 0);
    chk("R9", "ea held", int'(ea), exp_ea);
    chk("R9", "mem held", int'(mem_access), exp_mem);
    chk("R9", "pc held", int'(pc), exp_pc);
  endtask

  initial begin
    int xs[3], ys[3], ps[3];
    xs = '{16'h0000, 16'h7FC0, 16'hFFA0};
    ys = '{16'hFF80, 16'h0000, 16'h8010};
    ps = '{16'h0005, 16'h8000, 16'hFFF0};
    repeat (3) @(negedge clk);
    // R1: values while in reset
    chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    chk("R1", "ea in reset", int'(ea), 0);
    chk("R1", "mem in reset", int'(mem_access), 0);
    chk("R1", "pc in reset", int'(pc), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1", "ea after reset", int'(ea), 0);
    chk("R1", "pc after reset", int'(pc), 0);
    for (int k = 0; k < 3; k++)
      for (int m = 0; m < 8; m++)
        for (int c = 0; c < 2; c++)
          for (int lo = 0; lo < 256; lo++)
            one_request(m, lo, (lo ^ 8'h5A) & 8'hFF, xs[k], ys[k], ps[k], c[0]);
    // R2: back-to-back requests each yield a response
    @(negedge clk);
    req_valid = 1'b1; mode = 3'd0; op_hi = 8'h12; op_lo = 8'h34;
    @(negedge clk);
    op_hi = 8'hAB; op_lo = 8'hCD;
    chk("R2", "b2b first valid", int'(rsp_valid), 1);
    chk("R2", "b2b first ea", int'(ea), 16'h1234);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "b2b second valid", int'(rsp_valid), 1);
    chk("R2", "b2b second ea", int'(ea), 16'hABCD);
    @(negedge clk);
    chk("R2", "b2b strobe ends", int'(rsp_valid), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule